// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Node

This block is the per-peripheral logic for a serially chained priority interrupt scheme. Every node shares one active-low request line with its neighbours. The line is open-drain with a pull-up. A node that holds a pending request pulls that line low. Priority does not come from a central encoder. It passes down the chain: each node takes a grant from the node above it (`pri_in_i`) and hands a grant to the node below it (`pri_out_o`). The first node in the chain has its input tied high.

A node with no pending request passes the grant straight through. A node that is pending blocks the grant, so nodes further down cannot answer. When the processor starts an acknowledge cycle, the node stores a snapshot of its pending state at the start of that cycle. A request that arrives during the cycle therefore cannot change the chain. The one node that is pending in its snapshot and holds the grant places its own vector on the shared data bus. When the cycle ends, that node drops its request and gives a one-cycle serviced pulse.

Top module: `irq_chain_node`

## Requirements
- R1: After reset the node has no pending request: `irq_pull_o` = 0, `vec_drive_o` = 0, `serviced_o` = 0.
- R2: When `req_i` = 1 at a rising clock edge, the request becomes pending, and `irq_pull_o` is 1 from that edge until the request is serviced.
- R3: When no request is pending, `pri_out_o` equals `pri_in_i`. This is combinational.
- R4: While a request is pending and no acknowledge cycle is open, `pri_out_o` = 0.
- R5: The acknowledge strobe `ack_n_i` is active low and is sampled on rising edges. The edge that first samples it low opens the cycle and stores a snapshot of the pending state. A request that becomes pending during the cycle does not change `pri_out_o` and does not drive the vector.
- R6: While the cycle is open, if the snapshot is pending and `pri_in_i` = 1, then `vec_drive_o` = 1 and `vec_bus_o` = `VECTOR`. In that case `pri_out_o` = 0.
- R7: While the cycle is open with a pending snapshot but `pri_in_i` = 0, `vec_drive_o` stays 0 and `pri_out_o` = 0. The request stays pending after the cycle ends.
- R8: The edge that first samples `ack_n_i` high closes the cycle. If the node drove its vector during that cycle, this edge clears the pending request (unless `req_i` = 1 at the same edge) and sets `serviced_o` to 1 for exactly one cycle.
- R9: A request that arrives during a cycle the node did not win stays pending after the cycle, and `irq_pull_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Local request from the peripheral, sampled on rising edges |
| irq_pull_o | output | 1 | Drive-low enable for the shared open-drain request line |
| pri_in_i | input | 1 | Grant from the next higher node |
| pri_out_o | output | 1 | Grant to the next lower node |
| ack_n_i | input | 1 | Acknowledge strobe, active low |
| vec_drive_o | output | 1 | High while this node drives the bus |
| vec_bus_o | output | VEC_W | Vector onto the shared bus; high-impedance when not driving |
| serviced_o | output | 1 | One-cycle pulse after a won acknowledge cycle |

## Verification
`irq_pull_o` and the pending state change one rising edge after `req_i` is sampled. `pri_out_o` follows `pri_in_i` combinationally, in the same cycle. The vector is driven one edge after `ack_n_i` goes low, and `serviced_o` rises one edge after `ack_n_i` goes high, then lasts one cycle. The bench changes inputs on falling edges. It samples one time unit after the rising edge that should produce each result, and checks the grant at the same point while `pri_in_i` is held steady.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    typedef struct packed {
        logic pending;
        logic in_ack;
        logic snap;
        logic won;
        logic serviced;
    } node_state_t;
endpackage

// File: rtl/irq_node_state.sv
module irq_node_state
    import irq_chain_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_i,
    input  logic        ack_n_i,
    input  logic        drive_i,
    output node_state_t st_o
);
    node_state_t st_d, st_q;

    always_comb begin
        logic opening, closing;
        st_d     = st_q;
        opening  = !ack_n_i && !st_q.in_ack;
        closing  = ack_n_i && st_q.in_ack;
        st_d.serviced = 1'b0;
        if (opening) begin
            st_d.in_ack = 1'b1;
            st_d.snap   = st_q.pending;
            st_d.won    = 1'b0;
        end else if (st_q.in_ack && drive_i) begin
            st_d.won = 1'b1;
        end
        if (closing) begin
            st_d.in_ack = 1'b0;
            st_d.snap   = 1'b0;
            st_d.won    = 1'b0;
            if (st_q.won || drive_i) begin
                st_d.pending  = 1'b0;
                st_d.serviced = 1'b1;
            end
        end
        if (req_i)
            st_d.pending = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/irq_node_grant.sv
module irq_node_grant
    import irq_chain_pkg::*;
(
    input  node_state_t st_i,
    input  logic        pri_in_i,
    output logic        pri_out_o,
    output logic        drive_o
);
    logic holds_claim;

    always_comb begin
        holds_claim = st_i.in_ack ? st_i.snap : st_i.pending;
        pri_out_o   = pri_in_i && !holds_claim;
        drive_o     = st_i.in_ack && st_i.snap && pri_in_i;
    end
endmodule

// File: rtl/irq_node_vec_drv.sv
module irq_node_vec_drv #(
    parameter int                 VEC_W  = 8,
    parameter logic [VEC_W-1:0]   VECTOR = '0
) (
    input  logic             drive_i,
    output wire  [VEC_W-1:0] bus_o
);
    for (genvar b = 0; b < VEC_W; b++) begin : g_bit
        assign bus_o[b] = drive_i ? VECTOR[b] : 1'bz;
    end
endmodule

// File: rtl/irq_chain_node.sv
module irq_chain_node
    import irq_chain_pkg::*;
#(
    parameter int               VEC_W  = 8,
    parameter logic [VEC_W-1:0] VECTOR = 8'h3C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    output logic             irq_pull_o,
    input  logic             pri_in_i,
    output logic             pri_out_o,
    input  logic             ack_n_i,
    output logic             vec_drive_o,
    output wire  [VEC_W-1:0] vec_bus_o,
    output logic             serviced_o
);
    node_state_t st;
    logic        drive;

    irq_node_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .ack_n_i (ack_n_i),
        .drive_i (drive),
        .st_o    (st)
    );

    irq_node_grant u_grant (
        .st_i      (st),
        .pri_in_i  (pri_in_i),
        .pri_out_o (pri_out_o),
        .drive_o   (drive)
    );

    irq_node_vec_drv #(.VEC_W(VEC_W), .VECTOR(VECTOR)) u_vec (
        .drive_i (drive),
        .bus_o   (vec_bus_o)
    );

    assign irq_pull_o  = st.pending;
    assign vec_drive_o = drive;
    assign serviced_o  = st.serviced;
endmodule

// File: rtl/irq_chain_node_chk.sv
module irq_chain_node_chk (
    input logic clk,
    input logic rst_n,
    input logic req_i,
    input logic irq_pull_o,
    input logic pri_in_i,
    input logic pri_out_o,
    input logic vec_drive_o,
    input logic serviced_o
);
    assert_req_sets_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> irq_pull_o);
    assert_idle_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pull_o |-> (pri_out_o == pri_in_i));
    assert_drive_needs_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_drive_o |-> (pri_in_i && !pri_out_o));
    assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        serviced_o |=> !serviced_o);
    assert_clear_on_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (serviced_o && !$past(req_i)) |-> !irq_pull_o);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!irq_pull_o && !vec_drive_o && !serviced_o));
endmodule

bind irq_chain_node irq_chain_node_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .irq_pull_o  (irq_pull_o),
    .pri_in_i    (pri_in_i),
    .pri_out_o   (pri_out_o),
    .vec_drive_o (vec_drive_o),
    .serviced_o  (serviced_o)
);

// File: tb/sim_irq_chain_node.sv
`timescale 1ns/1ps
module sim_irq_chain_node;
    localparam logic [7:0] VEC = 8'h3C;

    logic clk = 0, rst_n = 0, req_i = 0, pri_in_i = 1, ack_n_i = 1;
    logic irq_pull_o, pri_out_o, vec_drive_o, serviced_o;
    wire  [7:0] vec_bus_o;
    int compared = 0, mismatched = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    irq_chain_node #(.VEC_W(8), .VECTOR(VEC)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .irq_pull_o(irq_pull_o),
        .pri_in_i(pri_in_i), .pri_out_o(pri_out_o), .ack_n_i(ack_n_i),
        .vec_drive_o(vec_drive_o), .vec_bus_o(vec_bus_o), .serviced_o(serviced_o)
    );

    // {pri_in, req, exp_pri_out, exp_pull}; sampled after the edge
    localparam logic [3:0] TABLE [8] = '{
        4'b1_0_1_0, 4'b0_0_0_0, 4'b1_0_1_0, 4'b1_1_0_1,
        4'b0_0_0_1, 4'b1_0_0_1, 4'b1_1_0_1, 4'b0_0_0_1
    };

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0; req_i = 0; ack_n_i = 1; pri_in_i = 1;
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        #(5 * 20000);
        $display("FAIL watchdog actual=hung expected=done");
        mismatched++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk("R1 pull", irq_pull_o, 0);
        chk("R1 drive", vec_drive_o, 0);
        chk("R1 serviced", serviced_o, 0);
        @(negedge clk); rst_n = 1;

        // R3 R4 R2 table walk
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pri_in_i = TABLE[i][3]; req_i = TABLE[i][2];
            step();
            chk($sformatf("R3/R4 row%0d pri_out", i), pri_out_o, TABLE[i][1]);
            chk($sformatf("R2 row%0d pull", i), irq_pull_o, TABLE[i][0]);
        end

        // Winning acknowledge: R6, R8
        do_reset();
        @(negedge clk); req_i = 1; pri_in_i = 1;
        @(negedge clk); req_i = 0;
        @(negedge clk); ack_n_i = 0;
        step();
        chk("R6 drive", vec_drive_o, 1);
        chk("R6 bus", vec_bus_o, VEC);
        chk("R6 pri_out blocked", pri_out_o, 0);
        @(negedge clk); ack_n_i = 1;
        step();
        chk("R8 serviced", serviced_o, 1);
        chk("R8 pull cleared", irq_pull_o, 0);
        chk("R8 drive off", vec_drive_o, 0);
        step();
        chk("R8 pulse one cycle", serviced_o, 0);

        // Late request during an acknowledge: R5, R9
        do_reset();
        @(negedge clk); ack_n_i = 0; pri_in_i = 1;
        step();
        @(negedge clk); req_i = 1;
        step();
        @(negedge clk); req_i = 0;
        #1;
        chk("R5 pri_out passes", pri_out_o, 1);
        chk("R5 no drive", vec_drive_o, 0);
        @(negedge clk); ack_n_i = 1;
        step();
        chk("R9 no service", serviced_o, 0);
        chk("R9 pull held", irq_pull_o, 1);
        chk("R9 blocks after", pri_out_o, 0);

        // Pending without grant: R7
        do_reset();
        @(negedge clk); req_i = 1; pri_in_i = 0;
        @(negedge clk); req_i = 0; ack_n_i = 0;
        step();
        chk("R7 no drive", vec_drive_o, 0);
        chk("R7 pri_out low", pri_out_o, 0);
        @(negedge clk); ack_n_i = 1;
        step();
        chk("R7 no service", serviced_o, 0);
        chk("R7 still pending", irq_pull_o, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule